// File: doc/BRIEF.md
# Mode-Select Clock Divider Bank

This block turns one test clock into six clock channels under the control of a 3-bit select code. With code 111 it derives every channel from the input clock by fixed integer ratios. Two codes are low-power states. Code 000 releases all outputs to high impedance. Code 001 freezes every output at a constant level. The five remaining codes belong to an external frequency synthesizer. In those codes this block only asserts the per-channel output enables, so that a behavioural model can supply the real clocks.

All dividers are decoded from one shared phase counter. Its period is the least common multiple of the channel ratios. A newly written select code takes effect only in the last cycle of that period. In that cycle every divided channel is low, so a mode change never leaves a shortened pulse. The undivided channel is gated by an enable that changes on the falling clock edge.

Top module: `clkdiv_bank`

## Requirements
- R1: With code 111, channel 0 has the input period, channel 1 twice the input period and channel 2 four times the input period, each high for half its period.
- R2: With code 111, channel 3 has three times and channel 4 five times the input period, high for 1.5 and 2.5 input cycles respectively.
- R3: With code 111, channel 5 has ten times the input period, high for five input cycles.
- R4: With code 111, every rising edge of channel 2 and of channel 5 coincides with a rising edge of channel 1 and of the input clock.
- R5: With code 000, all six enable bits are 0 (outputs at high impedance), all clock outputs are low, and no channel makes an edge.
- R6: With code 001, all six enable bits are 1, all clock outputs stay low, and no channel makes an edge.
- R7: With any of the codes 010 to 110, all six enable bits are 1 and the clock outputs stay low, leaving the clocks to the external synthesizer.
- R8: A new code takes effect within 60 input cycles of being applied, and at the cycle in which it takes effect all clock outputs are low.
- R9: While reset is high the block sits in the frozen state: all enable bits 1, all clock outputs low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Test input clock that every channel is derived from |
| rst | input | 1 | Synchronous reset, active high |
| freq_sel | input | 3 | Frequency/mode select code |
| clk_out | output | 6 | Channel clocks; bit i is channel i (ratios 1, 2, 4, 3, 5, 10) |
| drv_en | output | 6 | Per-channel output-drive enable; 0 means the pin is released to high impedance |

## Verification
The bench builds the block with its default ratio set 1, 2, 4, 3, 5 and 10. That set gives a 60-cycle phase period and two odd ratios. The 10 ns test clock puts every edge, including the half-cycle ones, on a whole nanosecond. So the bench can time each channel's period and high time exactly from edge timestamps. The bench then steps through all eight select codes. At each change it times the switch against the 60-cycle bound and counts edges in the stopped and external states.

// File: rtl/cdb_pkg.sv
`timescale 1ns/1ps
package cdb_pkg;

    localparam int unsigned NUM_CH = 6;

    // Division ratio per channel, channel 0 first.
    localparam int unsigned RATIO [NUM_CH] = '{1, 2, 4, 3, 5, 10};

    typedef enum logic [1:0] {
        ST_HIZ  = 2'd0,
        ST_HOLD = 2'd1,
        ST_EXT  = 2'd2,
        ST_DIV  = 2'd3
    } bank_state_e;

    function automatic int unsigned gcd_u(input int unsigned a, input int unsigned b);
        int unsigned x;
        int unsigned y;
        int unsigned t;
        x = a;
        y = b;
        for (int k = 0; k < 64; k++) begin
            if (y != 0) begin
                t = x % y;
                x = y;
                y = t;
            end
        end
        return x;
    endfunction

    function automatic int unsigned ratio_lcm();
        int unsigned acc;
        acc = 1;
        for (int i = 0; i < NUM_CH; i++) begin
            acc = (acc / gcd_u(acc, RATIO[i])) * RATIO[i];
        end
        return acc;
    endfunction

    localparam int unsigned PHASE_LEN = ratio_lcm();
    localparam int unsigned PW        = $clog2(PHASE_LEN);

    function automatic bank_state_e decode_sel(input logic [2:0] code);
        case (code)
            3'b000:  return ST_HIZ;
            3'b001:  return ST_HOLD;
            3'b111:  return ST_DIV;
            default: return ST_EXT;
        endcase
    endfunction

endpackage

// File: rtl/cdb_phase.sv
`timescale 1ns/1ps
module cdb_phase #(
    parameter int unsigned LEN = 60,
    parameter int unsigned W   = 6
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] phase,
    output logic         quiet_next
);
    localparam logic [W-1:0] LAST = W'(LEN - 1);
    localparam logic [W-1:0] PRE  = W'(LEN - 2);

    always_ff @(posedge clk) begin
        if (rst)                phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + 1'b1;
    end

    // Next cycle is the last of the period: the only cycle where all dividers are low.
    assign quiet_next = (phase == PRE);

    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
        ($past(phase) == LAST) |-> (phase == '0)); // R8
endmodule

// File: rtl/cdb_mode.sv
`timescale 1ns/1ps
module cdb_mode
    import cdb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  sel,
    input  logic        commit_ok,
    output bank_state_e cur
);
    bank_state_e want;
    assign want = decode_sel(sel);

    always_ff @(posedge clk) begin
        if (rst)                            cur <= ST_HOLD;
        else if (commit_ok && want != cur)  cur <= want;
    end
endmodule

// File: rtl/cdb_chan.sv
`timescale 1ns/1ps
module cdb_chan #(
    parameter int unsigned N  = 2,
    parameter int unsigned PW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [PW-1:0] phase,
    output logic          q
);
    generate
        if (N == 1) begin : g_pass
            logic gate_q;
            logic unused_ph;
            assign unused_ph = ^phase;
            // Enable moves only while the clock is low.
            always_ff @(negedge clk) begin
                if (rst) gate_q <= 1'b0;
                else     gate_q <= run;
            end
            assign q = clk & gate_q;
        end else if ((N % 2) == 0) begin : g_even
            localparam int unsigned HALF = N / 2;
            logic [31:0] pos;
            logic        unused_cr;
            assign unused_cr = clk ^ rst;
            assign pos = 32'(phase) % N;
            assign q   = run & (pos < HALF);

            AST_EVEN_EDGE_POINTS: assert property (@(posedge clk) disable iff (rst)
                (run && $past(run) && q != $past(q)) |-> (pos == 0 || pos == HALF)); // R1
        end else begin : g_odd
            localparam int unsigned HL = (N - 1) / 2;
            logic [31:0] pos;
            logic        lag_q;
            assign pos = 32'(phase) % N;
            // Half-cycle delayed copy widens the high time by half an input cycle.
            always_ff @(negedge clk) begin
                if (rst) lag_q <= 1'b0;
                else     lag_q <= (pos < HL);
            end
            assign q = run & ((pos < HL) | lag_q);

            AST_ODD_LOW_AT_END: assert property (@(posedge clk) disable iff (rst)
                (pos == N - 1) |-> !q); // R2
        end
    endgenerate
endmodule

// File: rtl/clkdiv_bank.sv
`timescale 1ns/1ps
module clkdiv_bank
    import cdb_pkg::*;
(
    input  logic              clk_in,
    input  logic              rst,
    input  logic [2:0]        freq_sel,
    output logic [NUM_CH-1:0] clk_out,
    output logic [NUM_CH-1:0] drv_en
);
    logic [PW-1:0]     phase;
    logic              quiet_next;
    bank_state_e       mode;
    logic              run;
    logic              stopped;
    logic [NUM_CH-1:0] div_q;

    cdb_phase #(.LEN(PHASE_LEN), .W(PW)) u_phase (
        .clk        (clk_in),
        .rst        (rst),
        .phase      (phase),
        .quiet_next (quiet_next)
    );

    cdb_mode u_mode (
        .clk       (clk_in),
        .rst       (rst),
        .sel       (freq_sel),
        .commit_ok (quiet_next),
        .cur       (mode)
    );

    assign run     = (mode == ST_DIV);
    assign stopped = (mode == ST_HIZ) || (mode == ST_HOLD);

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            cdb_chan #(.N(RATIO[i]), .PW(PW)) u_chan (
                .clk   (clk_in),
                .rst   (rst),
                .run   (run),
                .phase (phase),
                .q     (div_q[i])
            );
        end
    endgenerate

    assign clk_out = div_q;
    assign drv_en  = {NUM_CH{mode != ST_HIZ}};

    AST_COMMIT_AT_QUIET: assert property (@(posedge clk_in) disable iff (rst)
        (mode != $past(mode)) |-> ($past(phase) == PW'(PHASE_LEN - 2))); // R8
    AST_LOW_AT_SWITCH: assert property (@(posedge clk_in) disable iff (rst)
        (mode != $past(mode)) |-> (clk_out == '0)); // R8
    AST_STOP_NO_EDGE: assert property (@(posedge clk_in) disable iff (rst)
        (stopped && $past(stopped)) |-> $stable(clk_out)); // R5
    AST_EN_UNIFORM: assert property (@(posedge clk_in) disable iff (rst)
        ($countones(drv_en) == 0) || ($countones(drv_en) == NUM_CH)); // R6
endmodule

// File: tb/tb_clkdiv_bank.sv
`timescale 1ns/1ps
module tb_clkdiv_bank;
    localparam int CLK_P = 10;
    localparam int NCH   = 6;
    localparam int DIVS [NCH] = '{1, 2, 4, 3, 5, 10};

    logic           clk_in = 1'b0;
    logic           rst    = 1'b1;
    logic [2:0]     freq_sel = 3'b001;
    logic [NCH-1:0] clk_out;
    logic [NCH-1:0] drv_en;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_P/2) clk_in = ~clk_in;

    clkdiv_bank dut (
        .clk_in   (clk_in),
        .rst      (rst),
        .freq_sel (freq_sel),
        .clk_out  (clk_out),
        .drv_en   (drv_en)
    );

    longint prev_rise [NCH];
    longint last_rise [NCH];
    longint last_fall [NCH];
    int     edges     [NCH];

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_mon
            initial begin
                prev_rise[i] = 0; last_rise[i] = 0; last_fall[i] = 0; edges[i] = 0;
            end
            always @(posedge clk_out[i]) begin
                prev_rise[i] = last_rise[i];
                last_rise[i] = $time;
            end
            always @(negedge clk_out[i]) last_fall[i] = $time;
            always @(clk_out[i]) edges[i] = edges[i] + 1;
        end
    endgenerate

    // R4: coincidence of rising edges of channels 2 and 5 with channel 1 and the input clock
    int co_ok  = 0;
    int co_bad = 0;
    always @(posedge clk_out[5] or posedge clk_out[2]) begin
        #1;
        if (clk_out[1] && clk_out[0] && clk_in) co_ok = co_ok + 1;
        else                                   co_bad = co_bad + 1;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int k = 0; k < n; k++) @(negedge clk_in);
    endtask

    task automatic wait_en(input logic [NCH-1:0] exp, output int lat);
        lat = 0;
        while (drv_en !== exp && lat < 80) begin
            @(negedge clk_in);
            lat++;
        end
        #1;
    endtask

    task automatic edge_snapshot(output int snap [NCH]);
        for (int i = 0; i < NCH; i++) snap[i] = edges[i];
    endtask

    function automatic int edge_delta(input int snap [NCH]);
        int d;
        d = 0;
        for (int i = 0; i < NCH; i++) d += edges[i] - snap[i];
        return d;
    endfunction

    initial begin
        int lat;
        int snap [NCH];
        longint per;
        longint hi;

        // R9: reset state
        cycles(4);
        #1;
        check(drv_en == 6'h3F, "R9 enables in reset", drv_en, 6'h3F);
        check(clk_out == 6'h00, "R9 clocks in reset", clk_out, 0);
        @(negedge clk_in);
        rst = 1'b0;

        // R1/R2/R3: divided clocks
        freq_sel = 3'b111;
        cycles(200);
        #2;
        for (int i = 0; i < NCH; i++) begin
            string rq;
            rq = (i <= 2) ? "R1" : (i <= 4) ? "R2" : "R3";
            per = last_rise[i] - prev_rise[i];
            hi  = (last_fall[i] > last_rise[i]) ? (last_fall[i] - last_rise[i])
                                                : (last_fall[i] - prev_rise[i]);
            check(per == longint'(DIVS[i] * CLK_P), $sformatf("%s period ch%0d", rq, i), per, DIVS[i] * CLK_P);
            check(hi == longint'(DIVS[i] * CLK_P / 2), $sformatf("%s high time ch%0d", rq, i), hi, DIVS[i] * CLK_P / 2);
        end
        // R4
        check(co_bad == 0 && co_ok > 0, "R4 edge coincidence misses", co_bad, 0);

        // R8 and R5: running to high impedance
        @(negedge clk_in);
        freq_sel = 3'b000;
        wait_en(6'h00, lat);
        check(lat <= 61, "R8 latency into 000", lat, 61);
        check(clk_out == 6'h00, "R8 clocks at switch into 000", clk_out, 0);
        edge_snapshot(snap);
        cycles(100);
        #1;
        check(drv_en == 6'h00, "R5 enables", drv_en, 0);
        check(clk_out == 6'h00, "R5 clocks", clk_out, 0);
        check(edge_delta(snap) == 0, "R5 edge count", edge_delta(snap), 0);

        // R8: high impedance back to running
        @(negedge clk_in);
        freq_sel = 3'b111;
        wait_en(6'h3F, lat);
        check(lat <= 61, "R8 latency into 111", lat, 61);
        check(clk_out == 6'h00, "R8 clocks at switch into 111", clk_out, 0);
        cycles(100);

        // R6: frozen
        @(negedge clk_in);
        freq_sel = 3'b001;
        cycles(70);
        edge_snapshot(snap);
        cycles(100);
        #1;
        check(drv_en == 6'h3F, "R6 enables", drv_en, 6'h3F);
        check(clk_out == 6'h00, "R6 clocks", clk_out, 0);
        check(edge_delta(snap) == 0, "R6 edge count", edge_delta(snap), 0);

        // R7: external-synthesizer codes
        for (int c = 2; c <= 6; c++) begin
            @(negedge clk_in);
            freq_sel = 3'(c);
            cycles(70);
            edge_snapshot(snap);
            cycles(70);
            #1;
            check(drv_en == 6'h3F, $sformatf("R7 enables code %0d", c), drv_en, 6'h3F);
            check(clk_out == 6'h00 && edge_delta(snap) == 0,
                  $sformatf("R7 clocks quiet code %0d", c), edge_delta(snap), 0);
        end

        // R2: division resumes after external codes
        @(negedge clk_in);
        freq_sel = 3'b111;
        cycles(70);
        edge_snapshot(snap);
        cycles(60);
        check(edges[3] - snap[3] == 40, "R2 ch3 edges in 60 cycles", edges[3] - snap[3], 40);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks + 1);
        $finish;
    end
endmodule